// File: doc/BRIEF.md
# Super I/O Configuration Register Port

This block is the byte-wide configuration port of a multi-function peripheral controller. It sits on an ISA-style I/O bus and uses one address bit. An even address reaches an index latch and an odd address reaches the data window. Through that window software reaches three 8-bit configuration registers: the function-enable register at index 0, the function-map register at index 1, and the power/test register at index 2. All three registers are also driven out in parallel, so the peripheral functions they control can decode them directly.

On reset, the three registers take their starting contents from a 32-entry table. The table is indexed by a 5-bit strap input, which is sampled while reset is held. Reads of the index address first return a two-byte identification sequence. After that they return the selected index. Writing the index address ends the sequence at once.

Top module: `sio_cfg_port`

## Requirements
- R1: While `rst` is high on a clock edge, the three registers load from the strap table. Strap 1 gives enable 0x4F, map 0x11, power 0x00. Strap 30 gives 0x08, 0x10, 0x00. Strap 31 gives 0x00, 0x10, 0x02. `rd_data` becomes 0x00.
- R2: Reset sets the selected index to 0, so a data read (`addr`=1) right after reset returns the function-enable register.
- R3: After reset, the first index read (`addr`=0) returns 0x88 and the second returns 0x00. Every later index read returns the selected index. The sequence does not wrap back to 0x88 until the next reset.
- R4: An index write stores all 8 bits of `wr_data` as the selected index and ends the identification sequence. The next index read returns that value.
- R5: A data write with selected index 0, 1 or 2 updates the enable, map or power register respectively. The new value appears on the parallel output one cycle after the write strobe.
- R6: A data write with a selected index of 3 or more leaves all three registers unchanged.
- R7: A data read with a selected index of 3 or more returns 0x00.
- R8: Read data is registered. It appears on `rd_data` in the cycle after `rd_en` and holds its value in cycles with no read.
- R9: The index compare uses all 8 bits. Index 0x80 does not alias index 0: a data write there changes no register, and a data read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Configuration strap, sampled while rst is high |
| addr | input | 1 | 0 selects the index latch, 1 selects the data window |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Registered read data |
| fn_enable | output | 8 | Function-enable register |
| fn_map | output | 8 | Function-map register |
| pwr_test | output | 8 | Power/test register |

## Verification
Resets are applied with three different strap values. This shows that the table is really indexed by the strap, not fixed.

Index reads are repeated well past the identification bytes to show that the step counter saturates. The sequence is also restarted both by an index write and by a new reset, which separates those two exits.

Data accesses use in-range indices, index 3, and index 0x80. This tells a full 8-bit compare apart from one that drops high bits. Idle cycles between reads show whether `rd_data` is held or recomputed.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int DW      = 8,
  parameter int STRAP_W = 5,
  parameter int NREG    = 3,
  parameter logic [7:0] ID_BYTE = 8'h88
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data,
  output logic [DW-1:0]      fn_enable,
  output logic [DW-1:0]      fn_map,
  output logic [DW-1:0]      pwr_test
);
  localparam logic [1:0] ST_ID0 = 2'd0, ST_ID1 = 2'd1, ST_IDX = 2'd2;

  logic [DW-1:0] cfg [NREG];
  logic [DW-1:0] sel;
  logic [1:0]    step;
  logic          sel_ok;
  logic [DW-1:0] rd_next;

  function automatic logic [7:0] init_en(input logic [4:0] s);
    case (s)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5:         return 8'h4F;
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11:       return 8'h4B;
      5'd12, 5'd13, 5'd14, 5'd15:                 return 8'h0F;
      5'd16, 5'd17, 5'd18, 5'd19:                 return 8'h49;
      5'd20, 5'd21, 5'd22, 5'd23:                 return 8'h07;
      5'd24, 5'd25, 5'd26, 5'd27, 5'd28, 5'd29:   return 8'h47;
      5'd30:                                      return 8'h08;
      default:                                    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] init_map(input logic [4:0] s);
    case (s)
      5'd6, 5'd16, 5'd19:                         return 8'h00;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:     return 8'h11;
      5'd7, 5'd8, 5'd17, 5'd18:                   return 8'h01;
      5'd3, 5'd14, 5'd22, 5'd27:                  return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:                  return 8'h24;
      5'd5, 5'd29:                                return 8'h38;
      5'd9:                                       return 8'h09;
      5'd10, 5'd11:                               return 8'h08;
      default:                                    return 8'h10;
    endcase
  endfunction

  function automatic logic [7:0] init_pwr(input logic [4:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  assign sel_ok = (sel < DW'(NREG));

  always_comb begin
    if (addr) begin
      rd_next = sel_ok ? cfg[sel[1:0]] : '0;
    end else begin
      case (step)
        ST_ID0:  rd_next = DW'(ID_BYTE);
        ST_ID1:  rd_next = '0;
        default: rd_next = sel;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg[0]  <= DW'(init_en(5'(strap)));
      cfg[1]  <= DW'(init_map(5'(strap)));
      cfg[2]  <= DW'(init_pwr(5'(strap)));
      sel     <= '0;
      step    <= ST_ID0;
      rd_data <= '0;
    end else begin
      if (rd_en) begin
        rd_data <= rd_next;
        if (!addr && step != ST_IDX) step <= step + 2'd1;
      end
      if (wr_en) begin
        if (!addr) begin
          sel  <= wr_data;
          step <= ST_IDX;
        end else if (sel_ok) begin
          cfg[sel[1:0]] <= wr_data;
        end
      end
    end
  end

  assign fn_enable = cfg[0];
  assign fn_map    = cfg[1];
  assign pwr_test  = cfg[2];
endmodule

module sio_cfg_port_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst,
  input logic          addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] fn_enable,
  input logic [DW-1:0] fn_map,
  input logic [DW-1:0] pwr_test,
  input logic [DW-1:0] sel,
  input logic [1:0]    step
);
  // R6
  ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && sel >= DW'(3)) |=> ($stable(fn_enable) && $stable(fn_map) && $stable(pwr_test)));
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr && sel >= DW'(3)) |=> (rd_data == '0));
  // R5
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && sel == '0) |=> (fn_enable == $past(wr_data)));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R3
  id_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (step == 2'd2) |=> (step == 2'd2));
  // R4
  index_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> (sel == $past(wr_data)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .fn_enable(fn_enable),
  .fn_map(fn_map), .pwr_test(pwr_test), .sel(sel), .step(step)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 0;
  logic       rst = 1;
  logic [4:0] strap = 5'd1;
  logic       addr = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, fn_enable, fn_map, pwr_test;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  sio_cfg_port dut (
    .clk(clk), .rst(rst), .strap(strap), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .fn_enable(fn_enable), .fn_map(fn_map), .pwr_test(pwr_test)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int m_reg[3];
  int m_sel, m_step, m_rd;

  always @(posedge clk) begin
    int rv;
    if (rst) begin
      case (strap)
        5'd31: begin m_reg[0] = 'h00; m_reg[1] = 'h10; m_reg[2] = 'h02; end
        5'd30: begin m_reg[0] = 'h08; m_reg[1] = 'h10; m_reg[2] = 'h00; end
        default: begin m_reg[0] = 'h4F; m_reg[1] = 'h11; m_reg[2] = 'h00; end
      endcase
      m_sel = 0; m_step = 0; m_rd = 0;
    end else begin
      if (rd_en) begin
        if (addr) rv = (m_sel < 3) ? m_reg[m_sel] : 0;
        else begin
          rv = (m_step == 0) ? 'h88 : (m_step == 1) ? 0 : m_sel;
          if (m_step < 2) m_step = m_step + 1;
        end
        m_rd = rv;
      end
      if (wr_en) begin
        if (!addr) begin m_sel = int'(wr_data); m_step = 2; end
        else if (m_sel < 3) m_reg[m_sel] = int'(wr_data);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk("R5 fn_enable", int'(fn_enable), m_reg[0]);
      chk("R5 fn_map",    int'(fn_map),    m_reg[1]);
      chk("R5 pwr_test",  int'(pwr_test),  m_reg[2]);
      chk("R8 rd_data",   int'(rd_data),   m_rd);
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset(input logic [4:0] s);
    @(negedge clk); rst = 1; strap = s;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    do_reset(5'd1);
    @(negedge clk);
    chk("R1 strap1 enable", fn_enable, 'h4F);
    chk("R1 strap1 map", fn_map, 'h11);
    chk("R1 strap1 power", pwr_test, 'h00);
    chk("R1 rd_data reset", rd_data, 'h00);
    rd(1, v); chk("R2 data read idx0", v, 'h4F);
    rd(0, v); chk("R3 id byte", v, 'h88);
    rd(0, v); chk("R3 second id", v, 'h00);
    rd(0, v); chk("R3 index phase", v, 'h00);
    rd(0, v); chk("R3 saturate", v, 'h00);
    rd(0, v); chk("R3 no wrap", v, 'h00);
    repeat (3) @(negedge clk);
    chk("R8 hold", rd_data, 'h00);
    wr(0, 8'h01);
    rd(0, v); chk("R4 index readback", v, 'h01);
    wr(1, 8'h5A);
    chk("R5 map written", fn_map, 'h5A);
    wr(0, 8'h02); wr(1, 8'hA5);
    chk("R5 power written", pwr_test, 'hA5);
    rd(1, v); chk("R5 power readback", v, 'hA5);
    repeat (2) @(negedge clk);
    chk("R8 hold after read", rd_data, 'hA5);
    wr(0, 8'h00); wr(1, 8'h3C);
    chk("R5 enable written", fn_enable, 'h3C);
    wr(0, 8'h03); wr(1, 8'hFF);
    chk("R6 enable kept", fn_enable, 'h3C);
    chk("R6 map kept", fn_map, 'h5A);
    chk("R6 power kept", pwr_test, 'hA5);
    rd(1, v); chk("R7 read idx3", v, 'h00);
    wr(0, 8'h80); wr(1, 8'h77);
    chk("R9 enable kept", fn_enable, 'h3C);
    rd(1, v); chk("R9 read idx80", v, 'h00);
    rd(0, v); chk("R9 index readback", v, 'h80);
    do_reset(5'd31);
    @(negedge clk);
    chk("R1 strap31 enable", fn_enable, 'h00);
    chk("R1 strap31 map", fn_map, 'h10);
    chk("R1 strap31 power", pwr_test, 'h02);
    rd(0, v); chk("R3 id after reset", v, 'h88);
    wr(0, 8'h02);
    rd(0, v); chk("R4 write ends id", v, 'h02);
    do_reset(5'd30);
    @(negedge clk);
    chk("R1 strap30 enable", fn_enable, 'h08);
    chk("R1 strap30 map", fn_map, 'h10);
    chk("R1 strap30 power", pwr_test, 'h00);
    rd(1, v); chk("R2 data read after reset", v, 'h08);
    rd(0, v); chk("R3 id byte again", v, 'h88);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule